// File: doc/BRIEF.md
# Selectable Approximate Four-Input Compressor

This block reduces four bits of equal weight to a two-bit result: a carry bit worth two and a sum bit worth one. It has no carry input and no carry output. It is meant for the lower columns of a partial-product reduction tree. There, a small, known error is accepted in return for simpler logic. The block is purely combinational. The outputs follow the inputs within the same cycle, and the block has no clock and no stored state.

A static parameter selects one of four behaviours at elaboration:

- **Mode 0** returns the true count of ones, with one exception. The single pattern whose count needs three bits is held at three.
- **Modes 1 to 3** are approximate. Each one changes a fixed, small set of truth-table entries so that the gates behind the carry and sum outputs get simpler. Each higher mode accepts a larger set of wrong entries than the one below it.

Input bit order in the tables below is x1 x2 x3 x4, most significant first. So the pattern index is 8*x1 + 4*x2 + 2*x3 + x4.

Top module: `apx_compress42`

## Requirements
- R1: The result value is 2*carry + sum. For every pattern that is not named in R2, R4 or R5 for the selected mode, it equals the number of ones among x1..x4.
- R2: In every mode, input 1111 (index 15) gives carry=1 and sum=1 (value 3).
- R3: In mode 1, the output differs from the true count only on index 15.
- R4: In modes 2 and 3, input 0011 (x1=0, x2=0, x3=1, x4=1, index 3) gives carry=1 and sum=1 (value 3) instead of 2.
- R5: In mode 3, inputs 0111 (index 7) and 1011 (index 11) give carry=1 and sum=0 (value 2) instead of 3.
- R6: In mode 3, inputs 1101 (index 13) and 1110 (index 14) still give value 3. The change in R5 is not mirrored across the two input pairs.
- R7: Taken over all 16 patterns, the set of indices where the output differs from the true count is exactly:
  - {15} for modes 0 and 1
  - {3, 15} for mode 2
  - {3, 7, 11, 15} for mode 3
- R8: The output never differs from the true count by more than one.
- R9: The outputs are a pure function of the present inputs. A new input pattern is reflected at the ports in the same cycle, whatever came before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x1 | input | 1 | Compressor input bit, first of the first pair |
| x2 | input | 1 | Compressor input bit, second of the first pair |
| x3 | input | 1 | Compressor input bit, first of the second pair |
| x4 | input | 1 | Compressor input bit, second of the second pair |
| carry | output | 1 | Result bit of weight two |
| sum | output | 1 | Result bit of weight one |

## Verification
The block holds no state, so any wrong internal value shows up at carry and sum in the same cycle as the input pattern that triggers it. A wrong pair code or a misplaced patch term shows up as an extra entry in the mismatch set, or a missing one, for that mode. Because of this, all 16 patterns are applied in every mode, and the full mismatch set is compared, not only the listed entries. A second pass applies the patterns in a different order. This exposes any dependence on the previous input, which R9 forbids.

// File: rtl/apx_c42_pkg.sv
package apx_c42_pkg;

    localparam int C42_NUM_IN   = 4;
    localparam int C42_NUM_PAIR = C42_NUM_IN / 2;
    localparam int C42_CNT_W    = $clog2(C42_NUM_IN + 1);

    typedef enum int {
        C42_EXACT_SAT = 0,
        C42_APX_ONE   = 1,
        C42_APX_TWO   = 2,
        C42_APX_THREE = 3
    } c42_mode_e;

    // Two-bit code of one input pair: both ones, or exactly one
    typedef struct packed {
        logic both;
        logic odd;
    } c42_pair_t;

    typedef struct packed {
        logic carry;
        logic sum;
    } c42_out_t;

endpackage

// File: rtl/apx_c42_pairs.sv
module apx_c42_pairs
    import apx_c42_pkg::*;
(
    input  logic [C42_NUM_IN-1:0]   bits_i,
    output c42_pair_t               pair_o [C42_NUM_PAIR]
);

    // bits_i[3:2] form pair 0 (x1,x2), bits_i[1:0] pair 1 (x3,x4)
    for (genvar p = 0; p < C42_NUM_PAIR; p++) begin : g_pair
        localparam int HI = C42_NUM_IN - 1 - 2 * p;
        localparam int LO = HI - 1;
        always_comb begin
            pair_o[p].both = bits_i[HI] & bits_i[LO];
            pair_o[p].odd  = bits_i[HI] ^ bits_i[LO];
        end
    end

endmodule

// File: rtl/apx_c42_count.sv
module apx_c42_count
    import apx_c42_pkg::*;
(
    input  c42_pair_t               pair_i [C42_NUM_PAIR],
    output logic [C42_CNT_W-1:0]    count_o
);

    always_comb begin
        logic [C42_CNT_W-1:0] acc_d;
        acc_d = '0;
        for (int p = 0; p < C42_NUM_PAIR; p++) begin
            acc_d = acc_d + C42_CNT_W'({pair_i[p].both, pair_i[p].odd});
        end
        count_o = acc_d;
    end

endmodule

// File: rtl/apx_c42_adjust.sv
module apx_c42_adjust
    import apx_c42_pkg::*;
#(
    parameter int MODE = C42_EXACT_SAT
) (
    input  c42_pair_t               pair_i [C42_NUM_PAIR],
    input  logic [C42_CNT_W-1:0]    count_i,
    output c42_out_t                res_o
);

    logic saturate_d;
    logic lift_d;
    logic drop_d;

    // Pair 0 is x1x2, pair 1 is x3x4
    assign saturate_d = pair_i[0].both & pair_i[1].both;

    if (MODE >= C42_APX_TWO) begin : g_lift
        assign lift_d = ~pair_i[0].both & ~pair_i[0].odd & pair_i[1].both;
    end else begin : g_no_lift
        assign lift_d = 1'b0;
    end

    if (MODE == C42_APX_THREE) begin : g_drop
        assign drop_d = pair_i[0].odd & pair_i[1].both;
    end else begin : g_no_drop
        assign drop_d = 1'b0;
    end

    always_comb begin
        res_o = c42_out_t'(count_i[1:0]);
        if (saturate_d || lift_d) begin
            res_o = '{carry: 1'b1, sum: 1'b1};
        end else if (drop_d) begin
            res_o = '{carry: 1'b1, sum: 1'b0};
        end
    end

    always_comb begin
        // R5: a dropped entry never coexists with a lifted or saturated one
        a_r5_drop_exclusive: assert (!(drop_d && (lift_d || saturate_d)));
    end

endmodule

// File: rtl/apx_compress42.sv
module apx_compress42
    import apx_c42_pkg::*;
#(
    parameter int MODE = C42_EXACT_SAT
) (
    input  logic x1,
    input  logic x2,
    input  logic x3,
    input  logic x4,
    output logic carry,
    output logic sum
);

    localparam int MODE_MAX = C42_APX_THREE;

    if (MODE < 0 || MODE > MODE_MAX) begin : g_bad_mode
        $error("apx_compress42: MODE out of range");
    end

    logic [C42_NUM_IN-1:0]  bits_d;
    c42_pair_t              pair_d [C42_NUM_PAIR];
    logic [C42_CNT_W-1:0]   count_d;
    c42_out_t               res_d;

    assign bits_d = {x1, x2, x3, x4};

    apx_c42_pairs u_pairs (
        .bits_i (bits_d),
        .pair_o (pair_d)
    );

    apx_c42_count u_count (
        .pair_i  (pair_d),
        .count_o (count_d)
    );

    apx_c42_adjust #(.MODE(MODE)) u_adjust (
        .pair_i  (pair_d),
        .count_i (count_d),
        .res_o   (res_d)
    );

    assign carry = res_d.carry;
    assign sum   = res_d.sum;

    always_comb begin
        logic [C42_CNT_W-1:0] val_d;
        val_d = C42_CNT_W'({carry, sum});
        // R2: four ones held at three
        if (&bits_d) a_r2_all_ones: assert (carry && sum);
        // R8: result within one of the true count
        a_r8_error_bound: assert ((val_d == count_d) || (val_d + 1'b1 == count_d)
                                  || (val_d == count_d + 1'b1));
        // R3: mode 1 and mode 0 are exact except on the all-ones pattern
        if (MODE <= C42_APX_ONE && !(&bits_d))
            a_r3_exact_elsewhere: assert (val_d == count_d);
        // R4: 0011 raised to three in modes 2 and 3
        if (MODE >= C42_APX_TWO && bits_d == 4'b0011)
            a_r4_lift: assert (val_d == 3'd3);
        // R6: mode 3 leaves 1101 and 1110 at their count
        if (bits_d == 4'b1101 || bits_d == 4'b1110)
            a_r6_asymmetric: assert (val_d == 3'd3);
    end

endmodule

// File: tb/tb_apx_compress42.sv
module tb_apx_compress42;

    localparam int NMODE = 4;

    logic       clk;
    logic [3:0] x;
    logic       co [NMODE];
    logic       so [NMODE];

    int checks;
    int fails;
    bit done;

    initial clk = 1'b0;
    always #2 clk = ~clk;

    for (genvar m = 0; m < NMODE; m++) begin : g_mode
        apx_compress42 #(.MODE(m)) dut (
            .x1    (x[3]),
            .x2    (x[2]),
            .x3    (x[1]),
            .x4    (x[0]),
            .carry (co[m]),
            .sum   (so[m])
        );
    end

    function automatic int popcnt(input int idx);
        int n = 0;
        for (int b = 0; b < 4; b++) n += (idx >> b) & 1;
        return n;
    endfunction

    // Behavioural reference from the requirements
    function automatic int ref_val(input int mode, input int idx);
        if (idx == 15) return 3;                                  // R2
        if (mode >= 2 && idx == 3) return 3;                      // R4
        if (mode == 3 && (idx == 7 || idx == 11)) return 2;       // R5
        return popcnt(idx);                                       // R1
    endfunction

    function automatic string req_of(input int mode, input int idx);
        if (idx == 15) return "R2";
        if (mode >= 2 && idx == 3) return "R4";
        if (mode == 3 && (idx == 7 || idx == 11)) return "R5";
        if (mode == 3 && (idx == 13 || idx == 14)) return "R6";
        if (mode == 1) return "R3";
        return "R1";
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic sweep(input bit gray, inout logic [15:0] mask [NMODE]);
        for (int k = 0; k < 16; k++) begin
            int idx;
            idx = gray ? (k ^ (k >> 1)) : k;
            @(posedge clk);
            x = 4'(idx);
            @(negedge clk);
            for (int m = 0; m < NMODE; m++) begin
                int got;
                got = 2 * int'(co[m]) + int'(so[m]);
                // R9: same-cycle response to each new pattern
                check(req_of(m, idx), got, ref_val(m, idx),
                      $sformatf("mode %0d pattern %0d (R9 order %0d)", m, idx, gray));
                if (got != popcnt(idx)) mask[m][idx] = 1'b1;
            end
        end
    endtask

    initial begin
        logic [15:0] mask_a [NMODE];
        logic [15:0] mask_b [NMODE];
        logic [15:0] exp_mask [NMODE];
        checks = 0;
        fails  = 0;
        done   = 1'b0;
        x      = 4'd0;
        exp_mask[0] = 16'h8000;
        exp_mask[1] = 16'h8000;
        exp_mask[2] = 16'h8008;
        exp_mask[3] = 16'h8888;
        for (int m = 0; m < NMODE; m++) begin
            mask_a[m] = '0;
            mask_b[m] = '0;
        end
        @(negedge clk);
        for (int m = 0; m < NMODE; m++)
            check("R1", 2 * int'(co[m]) + int'(so[m]), 0,
                  $sformatf("initial zero input mode %0d", m));
        sweep(1'b0, mask_a);
        sweep(1'b1, mask_b);
        for (int m = 0; m < NMODE; m++) begin
            check("R7", int'(mask_a[m]), int'(exp_mask[m]),
                  $sformatf("mismatch set mode %0d ascending", m));
            check("R7", int'(mask_b[m]), int'(exp_mask[m]),
                  $sformatf("mismatch set mode %0d gray order", m));
        end
        // R8: error magnitude at most one across every mode and pattern
        for (int m = 0; m < NMODE; m++)
            for (int i = 0; i < 16; i++) begin
                int d;
                d = ref_val(m, i) - popcnt(i);
                if (d < -1 || d > 1) check("R8", d, 0, "reference error bound");
            end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule